// File: doc/BRIEF.md
# Buzzer and Clock Output Port Controller

This block drives a 4-pin output port from a 4-bit port register. Selected pins are taken over by special functions: pin 0 carries a square-wave buzzer tone, pin 3 carries the same tone inverted, and pin 2 carries a divided copy of the peripheral clock. These replace the register's DC level. The tone and the clock both come from a free-running 5-bit divider clocked by the peripheral clock. A one-bit frequency select gives a tone at clock/16 or clock/32.

Each special pin is gated by its own register bit. When the bit is 1 the pin carries its waveform. When the bit is 0 the pin holds low and does not follow the register level. The inverted buzzer pin is gated by either register bit 3 (separate mode) or register bit 0 (shared mode), chosen at build time. Enable changes are taken up only while the waveform being gated is low. As a result, every pulse on a special pin has the full half-period width.

Build-time parameters choose which pins carry special functions and which clock division appears on pin 2. A pin with no special function drives its register bit directly.

Top module: `bzck_port`

## Requirements
- R1: After reset the port register (`port_q`) is 0, the frequency select (`freq_q`) is 0, and all four pins are low.
- R2: With `freq_q` = 0 the tone has a period of 16 clocks. With `freq_q` = 1 it has a period of 32 clocks. The duty cycle is 50% in both cases.
- R3: With pin 0 special (BZ_PIN0 = 1), pin 0 carries the tone while register bit 0 is 1 and holds low while it is 0.
- R4: In separate mode (BZ3_SHARED = 0), pin 3 carries the inverse of the tone while register bit 3 is 1 and holds low while it is 0. Register bit 0 has no effect on pin 3. Pins 0 and 3 are never high together.
- R5: In shared mode (BZ3_SHARED = 1), register bit 0 gates both pin 0 and pin 3, so clearing it drives both low. Register bit 3 has no effect on pin 3.
- R6: With pin 2 special (CK_PIN2 = 1), pin 2 carries the clock divided by 2^CK_DIV_LOG2 (CK_DIV_LOG2 from 1 to 4) while register bit 2 is 1, and holds low while it is 0.
- R7: A pin without a special function drives its register bit. Pin 1 always works this way. The new level appears in the cycle after the write.
- R8: When pin 0 is plain DC (BZ_PIN0 = 0), the inverted buzzer function is not available, and pin 3 drives register bit 3 even if BZ_PIN3 = 1.
- R9: Gated pins rise only on a divider edge, and every high pulse lasts a full half-period. After a write, the pin 0 tone starts within one tone period.
- R10: A write with `port_wr` loads all four register bits at the next clock edge. A write with `freq_wr` loads the frequency select at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, which also clocks the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Port register write strobe |
| port_wdata | input | 4 | Port register write data |
| freq_wr | input | 1 | Frequency select write strobe |
| freq_wdata | input | 1 | Frequency select write data (1 gives clock/32) |
| port_q | output | 4 | Port register readback |
| freq_q | output | 1 | Frequency select readback |
| pin_o | output | 4 | Port pin levels |

## Verification
The waveforms are measured over 64-cycle windows by counting rising edges and high samples, at both tone frequencies and with several register patterns. Patterns 1000, 0001 and 1001 separate the gating of pin 3 by bit 3 from gating by bit 0, in both the separate-mode and shared-mode builds. A third build with pin 0 set to DC confirms that every pin, pin 3 included, then follows its register bit. The enable bit is toggled at many different phases while a monitor measures every high pulse on pin 0. A truncated pulse, or a tone that starts late, exposes gating that is not aligned to the divider.

// File: rtl/bzck_port.sv
module bzck_port #(
  parameter bit BZ_PIN0     = 1'b1,
  parameter bit BZ_PIN3     = 1'b1,
  parameter bit BZ3_SHARED  = 1'b0,
  parameter bit CK_PIN2     = 1'b1,
  parameter int CK_DIV_LOG2 = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_wr,
  input  logic [3:0] port_wdata,
  input  logic       freq_wr,
  input  logic       freq_wdata,
  output logic [3:0] port_q,
  output logic       freq_q,
  output logic [3:0] pin_o
);

  localparam int  DIV_W   = 5;
  localparam bit  USE_BZ3 = BZ_PIN3 && BZ_PIN0;
  localparam int  CK_BIT  = CK_DIV_LOG2 - 1;

  logic [DIV_W-1:0] div_q;
  logic tone, ck;
  logic run_bz, run_inv, run_ck;
  logic inv_ctl;
  logic div_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      freq_q <= 1'b0;
    end else begin
      if (port_wr) port_q <= port_wdata;
      if (freq_wr) freq_q <= freq_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tone       = freq_q ? div_q[DIV_W-1] : div_q[DIV_W-2];
  assign ck         = div_q[CK_BIT];
  assign div_unused = ^div_q;
  assign inv_ctl    = BZ3_SHARED ? port_q[0] : port_q[3];

  // each gate is reloaded only while the waveform it passes is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_bz  <= 1'b0;
      run_inv <= 1'b0;
      run_ck  <= 1'b0;
    end else begin
      if (!tone) run_bz  <= port_q[0];
      if (tone)  run_inv <= inv_ctl;
      if (!ck)   run_ck  <= port_q[2];
    end
  end

  assign pin_o[1] = port_q[1];

  if (BZ_PIN0) begin : g_p0_bz
    assign pin_o[0] = tone & run_bz;
  end else begin : g_p0_dc
    assign pin_o[0] = port_q[0];
  end

  if (CK_PIN2) begin : g_p2_ck
    assign pin_o[2] = ck & run_ck;
  end else begin : g_p2_dc
    assign pin_o[2] = port_q[2];
  end

  if (USE_BZ3) begin : g_p3_bz
    assign pin_o[3] = ~tone & run_inv;
  end else begin : g_p3_dc
    assign pin_o[3] = port_q[3];
  end

endmodule

// File: rtl/bzck_port_chk.sv
module bzck_port_chk #(
  parameter bit BZ_PIN0 = 1'b1,
  parameter bit BZ_PIN3 = 1'b1,
  parameter bit CK_PIN2 = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       port_wr,
  input logic [3:0] port_wdata,
  input logic [3:0] port_q,
  input logic [3:0] pin_o,
  input logic       tone
);

  localparam bit INV_ON = BZ_PIN0 && BZ_PIN3;

  a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> port_q == $past(port_wdata));

  a_r7_pin1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> pin_o[1] == $past(port_wdata[1]));

  a_r3_rise_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (BZ_PIN0 && $rose(pin_o[0])) |-> $past(port_q[0]));

  a_r4_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    INV_ON |-> !(pin_o[0] && pin_o[3]));

  a_r9_rise_on_divider: assert property (@(posedge clk) disable iff (!rst_n)
    (BZ_PIN0 && $rose(pin_o[0])) |-> $rose(tone));

  a_r6_ck_rise_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (CK_PIN2 && $rose(pin_o[2])) |-> $past(port_q[2]));

endmodule

bind bzck_port bzck_port_chk #(
  .BZ_PIN0(BZ_PIN0), .BZ_PIN3(BZ_PIN3), .CK_PIN2(CK_PIN2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
  .port_q(port_q), .pin_o(pin_o), .tone(tone)
);

// File: tb/test_bzck_port.sv
`timescale 1ns/1ps
module test_bzck_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_wr = 1'b0;
  logic [3:0] port_wdata = '0;
  logic freq_wr = 1'b0;
  logic freq_wdata = 1'b0;
  logic [3:0] q_m, q_s, q_d, p_m, p_s, p_d;
  logic f_m, f_s, f_d;
  int n_chk = 0, n_fail = 0;
  bit cur_freq = 1'b0;
  int run_len = 0, bad_pulses = 0, pulses = 0;

  always #10 clk = ~clk;

  bzck_port i_bzck_port (.clk(clk), .rst_n(rst_n), .port_wr(port_wr),
    .port_wdata(port_wdata), .freq_wr(freq_wr), .freq_wdata(freq_wdata),
    .port_q(q_m), .freq_q(f_m), .pin_o(p_m));
  bzck_port #(.BZ3_SHARED(1'b1)) i_bzck_port_shr (.clk(clk), .rst_n(rst_n),
    .port_wr(port_wr), .port_wdata(port_wdata), .freq_wr(freq_wr),
    .freq_wdata(freq_wdata), .port_q(q_s), .freq_q(f_s), .pin_o(p_s));
  bzck_port #(.BZ_PIN0(1'b0), .CK_PIN2(1'b0)) i_bzck_port_dc (.clk(clk),
    .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
    .freq_wr(freq_wr), .freq_wdata(freq_wdata), .port_q(q_d), .freq_q(f_d),
    .pin_o(p_d));

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_m[0]) run_len++;
      else if (run_len != 0) begin
        pulses++;
        if (run_len != (cur_freq ? 16 : 8)) bad_pulses++;
        run_len = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [3:0] v);
    @(negedge clk); port_wr = 1'b1; port_wdata = v;
    @(negedge clk); port_wr = 1'b0;
  endtask

  task automatic wr_freq(input bit v);
    @(negedge clk); freq_wr = 1'b1; freq_wdata = v;
    @(negedge clk); freq_wr = 1'b0; cur_freq = v;
  endtask

  function automatic logic [3:0] pick(input int inst);
    return inst == 0 ? p_m : (inst == 1 ? p_s : p_d);
  endfunction

  task automatic measure(input int inst, input int b, output int rises, output int highs);
    logic prev, cur;
    rises = 0; highs = 0; prev = 1'b0;
    for (int i = 0; i <= 64; i++) begin
      @(negedge clk);
      cur = pick(inst)[b];
      if (i > 0) begin
        if (cur && !prev) rises++;
        if (cur) highs++;
      end
      prev = cur;
    end
  endtask

  task automatic t_reset();
    chk(q_m == 4'h0, "R1 port_q", q_m, 0);
    chk(f_m == 1'b0, "R1 freq_q", f_m, 0);
    chk(p_m == 4'h0 && p_s == 4'h0 && p_d == 4'h0, "R1 pins", p_m, 0);
  endtask

  task automatic t_tone_freq();
    int r, h;
    wr_port(4'b0001);
    repeat (40) @(negedge clk);
    measure(0, 0, r, h);
    chk(r == 4, "R2 div16 rises", r, 4);
    chk(h == 32, "R2 div16 duty", h, 32);
    chk(q_m == 4'b0001, "R10 readback", q_m, 1);
    wr_port(4'b0000);
    repeat (40) @(negedge clk);
    measure(0, 0, r, h);
    chk(h == 0, "R3 pin0 off low", h, 0);
    wr_freq(1'b1);
    chk(f_m == 1'b1, "R10 freq readback", f_m, 1);
    wr_port(4'b0001);
    repeat (70) @(negedge clk);
    measure(0, 0, r, h);
    chk(r == 2, "R2 div32 rises", r, 2);
    chk(h == 32, "R2 div32 duty", h, 32);
    wr_port(4'b0000);
    repeat (70) @(negedge clk);
    wr_freq(1'b0);
  endtask

  task automatic t_inverted();
    int r, h, mism;
    wr_port(4'b1000);
    repeat (40) @(negedge clk);
    measure(0, 3, r, h);
    chk(r == 4 && h == 32, "R4 sep bit3 drives pin3", r, 4);
    measure(1, 3, r, h);
    chk(h == 0, "R5 shared bit3 no effect", h, 0);
    measure(0, 0, r, h);
    chk(h == 0, "R3 pin0 low with bit0 clear", h, 0);
    wr_port(4'b0001);
    repeat (40) @(negedge clk);
    measure(0, 3, r, h);
    chk(h == 0, "R4 sep bit0 no effect on pin3", h, 0);
    measure(1, 3, r, h);
    chk(r == 4 && h == 32, "R5 shared bit0 drives pin3", r, 4);
    wr_port(4'b1001);
    repeat (40) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (p_m[3] != !p_m[0]) mism++;
    end
    chk(mism == 0, "R4 pin3 inverse of pin0", mism, 0);
    wr_port(4'b1000);
    repeat (40) @(negedge clk);
    measure(1, 3, r, h);
    chk(h == 0, "R5 shared clear bit0 silences pin3", h, 0);
    measure(1, 0, r, h);
    chk(h == 0, "R5 shared clear bit0 silences pin0", h, 0);
    wr_port(4'b0000);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_clock_out();
    int r, h;
    wr_port(4'b0100);
    repeat (8) @(negedge clk);
    measure(0, 2, r, h);
    chk(r == 32 && h == 32, "R6 clock div2", r, 32);
    chk(p_m[1] == 1'b0, "R7 pin1 untouched", p_m[1], 0);
    wr_port(4'b0000);
    repeat (8) @(negedge clk);
    measure(0, 2, r, h);
    chk(h == 0, "R6 clock off low", h, 0);
  endtask

  task automatic t_dc_pins();
    wr_port(4'b1010);
    chk(p_m[1] == 1'b1, "R7 pin1 next cycle", p_m[1], 1);
    chk(p_d == 4'b1010, "R8 dc build pins follow", p_d, 10);
    wr_port(4'b0101);
    chk(p_d == 4'b0101, "R8 dc build pins follow", p_d, 5);
    chk(p_d[3] == 1'b0, "R8 pin3 is dc", p_d[3], 0);
    wr_port(4'b0000);
    chk(p_m[1] == 1'b0, "R7 pin1 cleared", p_m[1], 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_glitch();
    int wait_c, late;
    late = 0;
    pulses = 0; bad_pulses = 0;
    for (int k = 0; k < 20; k++) begin
      wr_port(4'b0001);
      wait_c = 0;
      while (!p_m[0] && wait_c < 40) begin @(negedge clk); wait_c++; end
      if (wait_c > 16) late++;
      repeat (k + 1) @(negedge clk);
      wr_port(4'b0000);
      repeat (k % 7 + 1) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(late == 0, "R9 start within one period", late, 0);
    chk(bad_pulses == 0 && pulses > 0, "R9 full-width pulses", bad_pulses, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tone_freq();
    t_inverted();
    t_clock_out();
    t_dc_pins();
    t_glitch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule